// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block produces one pulse-width modulated output from a fast input clock. A coded prescaler divides the clock by one of a fixed set of non-power-of-two ratios (or passes it through undivided). A 16-bit phase counter then steps once per prescaled tick. Each output period spans a programmable number of ticks, and the first part of the period is the active phase. The output can repeat periods continuously or emit one pulse on request. The active level is selectable, and a bypass path can drive the raw input clock onto the pin.

Software programs the block through a 32-bit register bus with two words: a control word at offset 0x0 and a period word at offset 0x4. A new period setting is held pending and takes effect only at the next period boundary. A read-only busy flag in the control word shows that an update is still waiting. The asynchronous active-low reset is released synchronously through a two-stage synchronizer, so state comes out of reset two clock edges after `rst_n` rises.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset, both registers read 0, the busy flag reads 0 and `pwm_out` is 1 (the inactive level for active-low polarity).
- R2: The control word holds prescale code in bits 3:0, run enable in bit 4, polarity in bit 5, clock gate in bit 6, mode in bit 7, pulse start in bit 8 and bypass in bit 9. Bit 28 reads the busy flag, and writes to it are ignored. All other bits read 0. The period word at 0x4 reads back the last value written. Any other offset reads 0 and ignores writes.
- R3: Prescale codes 0,1,2,3,4 divide the clock by 120,180,240,360,480. Codes 8..12 divide by 12000,24000,36000,48000,72000. Code 15 divides by 1. With code c, the counter advances once every divisor(c) clock cycles.
- R4: Codes 5,6,7,13,14 are reserved. With a reserved code, the output holds the inactive level and the counter stays at zero, so selecting a valid code later starts at the beginning of the active phase.
- R5: The output toggles only when run enable and clock gate are both 1. If either is 0, the output holds the inactive level.
- R6: In continuous mode (bit 7 = 0), each period lasts T+1 ticks, where T is period bits 31:16. The first A ticks are active, where A is period bits 15:0. The active phase starts on the first clock edge after enabling.
- R7: With polarity 1 the active phase drives 1 and the inactive level is 0. With polarity 0 it is the reverse.
- R8: If A >= T+1, the output is active for the whole period. If A = 0, it is never active.
- R9: A period write sets busy on the next edge. While counting, the new T and A take effect at the tick that ends the current period, and busy clears on that same edge. While counting is stopped, they take effect on the next edge.
- R10: In single-pulse mode (bit 7 = 1), the output stays inactive until bit 8 is written as 1. It then produces exactly one period (A active ticks, then the rest inactive) and returns to the inactive level.
- R11: With bypass set and both enable and gate set, `pwm_out` follows `clk`.
- R12: The pulse-start bit clears itself at the end of the pulse. It is stored only when it is written together with mode 1, and it also clears when the block stops running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
A control or period write lands on the clock edge that samples `bus_we`, and read data is combinational. Register effects are therefore checked at the falling edge that follows the write. With divide-by-one, the output shows the new phase half a cycle after each counting edge. Sample j after enabling holds phase j mod (T+1), and a deferred period update appears at the sample after the boundary tick. With a prescale divisor N, the first active-to-inactive change is due N edges after enabling. The bench samples exactly at N-1 and N, and at 2N-1 and 2N for the return to active.

// File: rtl/pwmp_pkg.sv
package pwmp_pkg;

  localparam int PRE_W = 4;
  localparam int DIV_W = 17;

  // Control word image of bits 9:0; the packing matches the bus bit positions.
  typedef struct packed {
    logic             byp;
    logic             start;
    logic             mode;
    logic             gate;
    logic             pol;
    logic             en;
    logic [PRE_W-1:0] code;
  } ctrl_t;

  // Divisor for a prescale code; zero marks a reserved code.
  function automatic logic [DIV_W-1:0] pre_divisor(input logic [PRE_W-1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = DIV_W'(120);
      4'd1:    d = DIV_W'(180);
      4'd2:    d = DIV_W'(240);
      4'd3:    d = DIV_W'(360);
      4'd4:    d = DIV_W'(480);
      4'd8:    d = DIV_W'(12000);
      4'd9:    d = DIV_W'(24000);
      4'd10:   d = DIV_W'(36000);
      4'd11:   d = DIV_W'(48000);
      4'd12:   d = DIV_W'(72000);
      4'd15:   d = DIV_W'(1);
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwmp_prescaler.sv
module pwmp_prescaler #(
  parameter int DIV_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div - DIV_W'(1));
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: with a divisor above one, two ticks never fall on adjacent edges
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DIV_W'(1) && run) |=> !tick);

endmodule

// File: rtl/pwmp_counter.sv
module pwmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopped,
  input  logic             tick,
  input  logic             pend,
  input  logic [CNT_W-1:0] pend_total,
  input  logic [CNT_W-1:0] pend_active,
  output logic             wrap,
  output logic             load,
  output logic             phase_act
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tot_q, tot_d;
  logic [CNT_W-1:0] act_q, act_d;

  always_comb begin
    wrap      = !stopped && tick && (cnt_q == tot_q);
    load      = pend && (stopped || wrap);
    phase_act = cnt_q < act_q;
    cnt_d     = cnt_q;
    if (stopped)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
    tot_d = load ? pend_total  : tot_q;
    act_d = load ? pend_active : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tot_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      tot_q <= tot_d;
      act_q <= act_d;
    end
  end

  // R6: the phase counter never runs past the live terminal count
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= tot_q);

endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);

  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PER_OFS  = ADDR_W'(4);
  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int BUSY_BIT = 28;

  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] ptot_q, ptot_d, pact_q, pact_d;
  logic             busy_q, busy_d;

  logic             ctrl_wr, per_wr, running, stopped, tick, wrap, load, phase_act;
  logic [DIV_W-1:0] div;
  ctrl_t            wr_ctrl;

  assign ctrl_wr = bus_we && (bus_addr == CTRL_OFS);
  assign per_wr  = bus_we && (bus_addr == PER_OFS);
  assign wr_ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign div     = pre_divisor(ctrl_q.code);
  assign running = ctrl_q.en && ctrl_q.gate && (div != '0);
  assign stopped = !running || (ctrl_q.mode && !ctrl_q.start);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d       = wr_ctrl;
      ctrl_d.start = wr_ctrl.start && wr_ctrl.mode;
    end else if (!running || (wrap && ctrl_q.mode)) begin
      ctrl_d.start = 1'b0;
    end
    ptot_d = per_wr ? bus_wdata[2*CNT_W-1:CNT_W] : ptot_q;
    pact_d = per_wr ? bus_wdata[CNT_W-1:0]       : pact_q;
    busy_d = per_wr ? 1'b1 : (load ? 1'b0 : busy_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      ptot_q <= '0;
      pact_q <= '0;
      busy_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ptot_q <= ptot_d;
      pact_q <= pact_d;
      busy_q <= busy_d;
    end
  end

  pwmp_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (running),
    .div   (div),
    .tick  (tick)
  );

  pwmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (srst_n),
    .stopped     (stopped),
    .tick        (tick),
    .pend        (busy_q),
    .pend_total  (ptot_q),
    .pend_active (pact_q),
    .wrap        (wrap),
    .load        (load),
    .phase_act   (phase_act)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS) begin
      bus_rdata[CTRL_W-1:0] = ctrl_q;
      bus_rdata[BUSY_BIT]   = busy_q;
    end else if (bus_addr == PER_OFS) begin
      bus_rdata[2*CNT_W-1:0] = {ptot_q, pact_q};
    end
  end

  always_comb begin
    if (ctrl_q.byp && ctrl_q.en && ctrl_q.gate) pwm_out = clk;
    else if (!stopped && phase_act)             pwm_out = ctrl_q.pol;
    else                                        pwm_out = !ctrl_q.pol;
  end

  // R9: a period write always leaves the update pending
  a_r9_busy_set: assert property (@(posedge clk) disable iff (!srst_n)
    per_wr |=> busy_q);

  // R9: the pending flag drops on the edge that applies the new values
  a_r9_busy_clear: assert property (@(posedge clk) disable iff (!srst_n)
    (load && !per_wr) |=> !busy_q);

  // R10 / R12: the end of a single pulse withdraws the start request
  a_r10_pulse_end: assert property (@(posedge clk) disable iff (!srst_n)
    (wrap && ctrl_q.mode && !ctrl_wr) |=> !ctrl_q.start);

  // R12: a stored start request implies single-pulse mode
  a_r12_start_mode: assert property (@(posedge clk) disable iff (!srst_n)
    ctrl_q.start |-> ctrl_q.mode);

endmodule

// File: tb/pwm_prescaled_bench.sv
`timescale 1ns/1ps
module pwm_prescaled_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwm_prescaled u_pwm_prescaled (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
    bus_addr = 4'h0;
  endtask

  task automatic restart(input logic [15:0] t, input logic [15:0] a);
    wr(4'h0, 32'h0);
    wr(4'h4, {t, a});
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R1 period", d, 32'h0);
    chk("R1 out", pwm_out, 1);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FC2A);
    rd(4'h0, d); chk("R2 ctrl mask", d, 32'h0000_002A);
    wr(4'h4, 32'hABCD_1234);
    rd(4'h4, d); chk("R2 period", d, 32'hABCD_1234);
    wr(4'h8, 32'h0000_00FF);
    rd(4'h0, d); chk("R2 unmapped write", d, 32'h0000_002A);
    rd(4'h8, d); chk("R2 unmapped read", d, 32'h0);
  endtask

  task automatic t_busy_stopped;
    wr(4'h0, 32'h0);
    wr(4'h4, {16'd4, 16'd2});
    @(negedge clk); #1; chk("R9 busy set", bus_rdata[28], 1);
    @(negedge clk); #1; chk("R9 stopped load", bus_rdata[28], 0);
  endtask

  task automatic t_continuous;
    restart(16'd4, 16'd2);
    wr(4'h0, 32'h7F);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk); #1;
      chk("R6 cycle", pwm_out, ((j % 5) < 2) ? 1 : 0);
    end
  endtask

  task automatic t_deferred;
    logic exp_o, exp_b;
    restart(16'd4, 16'd2);
    wr(4'h0, 32'h7F);
    wr(4'h4, {16'd2, 16'd1});
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); #1;
      if (j < 4) begin exp_o = (j == 0); exp_b = 1'b1; end
      else begin exp_o = (((j - 4) % 3) == 0); exp_b = 1'b0; end
      chk("R9 deferred out", pwm_out, exp_o);
      chk("R9 busy", bus_rdata[28], exp_b);
    end
  endtask

  task automatic t_polarity;
    restart(16'd3, 16'd1);
    wr(4'h0, 32'h5F);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); #1;
      chk("R7 low active", pwm_out, ((j % 4) == 0) ? 0 : 1);
    end
  endtask

  task automatic t_extremes;
    restart(16'd3, 16'd10);
    wr(4'h0, 32'h7F);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); #1; chk("R8 full active", pwm_out, 1);
    end
    restart(16'd3, 16'd0);
    wr(4'h0, 32'h7F);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); #1; chk("R8 zero active", pwm_out, 0);
    end
  endtask

  task automatic t_reserved;
    restart(16'd4, 16'd2);
    wr(4'h0, 32'h75);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk); #1; chk("R4 code 5", pwm_out, 0);
    end
    wr(4'h0, 32'h7D);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk); #1; chk("R4 code 13", pwm_out, 0);
    end
    wr(4'h0, 32'h7F);
    @(negedge clk); #1; chk("R4 restart at zero", pwm_out, 1);
    @(negedge clk); #1; chk("R4 second tick", pwm_out, 1);
    @(negedge clk); #1; chk("R4 third tick", pwm_out, 0);
  endtask

  task automatic t_gate_enable;
    restart(16'd4, 16'd2);
    wr(4'h0, 32'h3F);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); #1; chk("R5 gate off", pwm_out, 0);
    end
    wr(4'h0, 32'h6F);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); #1; chk("R5 enable off", pwm_out, 0);
    end
  endtask

  task automatic t_single;
    logic [31:0] d;
    restart(16'd3, 16'd2);
    wr(4'h0, 32'h17F);
    rd(4'h0, d); chk("R12 start needs mode", d[8], 0);
    wr(4'h0, 32'hFF);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); #1; chk("R10 idle", pwm_out, 0);
    end
    wr(4'h0, 32'h1FF);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk); #1;
      chk("R10 one pulse", pwm_out, (j < 2) ? 1 : 0);
      if (j == 1) chk("R12 start held", bus_rdata[8], 1);
    end
    rd(4'h0, d); chk("R12 start cleared", d[8], 0);
  endtask

  task automatic t_prescale(input logic [3:0] code, input int n);
    restart(16'd1, 16'd1);
    wr(4'h0, 32'h70 | 32'(code));
    for (int j = 0; j <= 2 * n; j++) begin
      @(negedge clk); #1;
      if (j == n - 1)     chk("R3 before tick", pwm_out, 1);
      if (j == n)         chk("R3 at tick", pwm_out, 0);
      if (j == 2 * n - 1) chk("R3 before wrap", pwm_out, 0);
      if (j == 2 * n)     chk("R3 at wrap", pwm_out, 1);
    end
  endtask

  task automatic t_bypass;
    restart(16'd4, 16'd2);
    wr(4'h0, 32'h27F);
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); #1; chk("R11 clock high", pwm_out, 1);
      @(negedge clk); #1; chk("R11 clock low", pwm_out, 0);
    end
    wr(4'h0, 32'h23F);
    @(posedge clk); #1; chk("R11 needs gate", pwm_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_busy_stopped;
    t_continuous;
    t_deferred;
    t_polarity;
    t_extremes;
    t_reserved;
    t_gate_enable;
    t_single;
    t_prescale(4'd0, 120);
    t_prescale(4'd1, 180);
    t_prescale(4'd8, 12000);
    t_bypass;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule